// File: doc/BRIEF.md
# Device Power State Register Controller

This block holds the power management control/status register of a PCIe function and tracks which device power state the function is in: D0 uninitialized, D0 active, D1, D2 or D3hot. Software reaches it through a small configuration port with two word addresses. Address 0 is the power management control/status word. Address 1 holds the command enable bits. A write to the power state field is checked against the optional states that the function advertises and against the allowed direction of travel. A write that fails either check leaves the committed state unchanged.

When the function enters D1, D2 or D3hot, the block raises a level request for the link to enter L1. The request stays up until the next configuration access. A return from D3hot to D0 depends on a read-only context retention strap. If the strap is clear, the block issues a single-cycle soft reset pulse and clears the command enables, so the function comes back in D0 uninitialized. If the strap is set, no pulse is issued and the command enables are kept. Strap inputs also advertise optional D1 and D2 support.

Top module: `pm_state_ctrl`

## Requirements
- R1: A read of address 0 returns the committed power state in bits [1:0] (00 = D0, 01 = D1, 10 = D2, 11 = D3hot), the retention strap in bit 2 and the wake enable in bit 8. All other bits of the 16-bit word read 0. Address 1 returns the command enables in bits [2:0] and zero above.
- R2: A write to address 0 that requests D1 while `strap_d1_ok` is 0, or D2 while `strap_d2_ok` is 0, leaves the power state unchanged.
- R3: A write that moves to a lower-numbered non-D0 state (D2 to D1, D3hot to D1, D3hot to D2) leaves the power state unchanged.
- R4: A supported write that is not backward takes effect on the clock edge at which it is presented. D0 may go to any state, and any state may return to D0.
- R5: `l1_req` is 1 in the cycle that follows an accepted write which moves the state to D1, D2 or D3hot.
- R6: Any configuration read or write that is not itself such an entry drops `l1_req` to 0 on the same edge.
- R7: An accepted D3hot-to-D0 write while `strap_keep_ctx` is 0 makes `soft_rst` 1 for exactly the next cycle and clears the command enables. The wake enable (address 0 bit 8) is kept.
- R8: When `strap_keep_ctx` is 1, a D3hot-to-D0 return gives no `soft_rst` pulse and keeps the command enables.
- R9: `dstate` encodes 0 = D0 uninitialized, 1 = D0 active, 2 = D1, 3 = D2, 4 = D3hot. The function is in D0 active when it is in D0 and any command enable bit is set.
- R10: While `rst_n` is low, the power state is D0, the command enables and wake enable are 0, and `l1_req` and `soft_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fundamental reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 1 | Word select: 0 = power control/status, 1 = command |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data (combinational on `cfg_addr`) |
| strap_d1_ok | input | 1 | D1 is advertised as supported |
| strap_d2_ok | input | 1 | D2 is advertised as supported |
| strap_keep_ctx | input | 1 | Context is retained across a D3hot-to-D0 return |
| dstate | output | 3 | Current device power state |
| l1_req | output | 1 | Request for the link to enter L1 |
| soft_rst | output | 1 | One-cycle soft reset for the configuration registers |

## Verification
The assertions assume that the three strap inputs change only while `rst_n` is low. Under that assumption, an unsupported state can never become committed, and a retaining function never pulses soft reset. The stimulus sets the straps only while reset is held, and then sweeps every combination of starting state and requested state. It repeats the sweep for every strap setting and applies reset before each case. It drives the strobes one access at a time, away from the clock edge, so that each check sees the result of exactly one access.

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl #(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              strap_d1_ok,
  input  logic              strap_d2_ok,
  input  logic              strap_keep_ctx,
  output logic [2:0]        dstate,
  output logic              l1_req,
  output logic              soft_rst
);
  localparam int WAKE_BIT = 8;
  localparam logic [1:0] ST_D0 = 2'd0, ST_D1 = 2'd1, ST_D2 = 2'd2, ST_D3 = 2'd3;

  logic [1:0]       ps;
  logic [CMD_W-1:0] cmd;
  logic             wake_en;

  logic       wr_pm, wr_cmd, supported, legal, accept, entry, do_srst;
  logic [1:0] tgt;

  assign tgt       = cfg_wdata[1:0];
  assign wr_pm     = cfg_wr && (cfg_addr == 1'b0);
  assign wr_cmd    = cfg_wr && (cfg_addr == 1'b1);
  assign supported = !((tgt == ST_D1) && !strap_d1_ok) && !((tgt == ST_D2) && !strap_d2_ok);
  assign legal     = supported && ((tgt == ST_D0) || (tgt >= ps));
  assign accept    = wr_pm && legal;
  assign entry     = accept && (tgt != ST_D0) && (tgt != ps);
  assign do_srst   = accept && (ps == ST_D3) && (tgt == ST_D0) && !strap_keep_ctx;

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[DATA_W-1:WAKE_BIT+1], cfg_wdata[WAKE_BIT-1:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps       <= ST_D0;
      cmd      <= '0;
      wake_en  <= 1'b0;
      l1_req   <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= do_srst;
      if (wr_pm) wake_en <= cfg_wdata[WAKE_BIT];
      if (accept) ps <= tgt;
      if (do_srst) cmd <= '0;
      else if (wr_cmd) cmd <= cfg_wdata[CMD_W-1:0];
      if (entry) l1_req <= 1'b1;
      else if (cfg_wr || cfg_rd) l1_req <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == 1'b0) begin
      cfg_rdata[1:0]      = ps;
      cfg_rdata[2]        = strap_keep_ctx;
      cfg_rdata[WAKE_BIT] = wake_en;
    end else begin
      cfg_rdata[CMD_W-1:0] = cmd;
    end
  end

  assign dstate = (ps == ST_D0) ? {2'b00, |cmd} : {1'b0, ps} + 3'd1;

  AST_NO_UNSUP_D1: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_d1_ok |-> ps != ST_D1); // R2
  AST_NO_UNSUP_D2: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_d2_ok |-> ps != ST_D2); // R2
  AST_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ps != $past(ps) && ps != ST_D0) |-> ps > $past(ps)); // R3
  AST_L1_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ps != $past(ps) && ps != ST_D0) |-> l1_req); // R5
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R7
  AST_SRST_FROM_D3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (ps == ST_D0 && $past(ps) == ST_D3 && cmd == '0)); // R7
  AST_KEEP_NO_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    strap_keep_ctx |-> !soft_rst); // R8
endmodule

// File: tb/pm_state_ctrl_bench.sv
module pm_state_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        strap_d1_ok = 1'b0, strap_d2_ok = 1'b0, strap_keep_ctx = 1'b0;
  logic [2:0]  dstate;
  logic        l1_req, soft_rst;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_state_ctrl u_pm_state_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .strap_d1_ok(strap_d1_ok),
    .strap_d2_ok(strap_d2_ok), .strap_keep_ctx(strap_keep_ctx), .dstate(dstate),
    .l1_req(l1_req), .soft_rst(soft_rst));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit d1, input bit d2, input bit keep);
    rst_n = 1'b0;
    strap_d1_ok = d1; strap_d2_ok = d2; strap_keep_ctx = keep;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input bit a, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [15:0] d);
    cfg_rd = 1'b1; cfg_addr = a;
    #2 d = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    @(negedge clk);
    do_reset(1'b1, 1'b1, 1'b0);
    chk("R10 dstate after reset", dstate, 0);
    chk("R10 l1_req after reset", l1_req, 0);
    chk("R10 soft_rst after reset", soft_rst, 0);
    rd(1'b0, rv); chk("R10/R1 pm word after reset", rv, 0);
    rd(1'b1, rv); chk("R10/R1 cmd word after reset", rv, 0);
    wr(1'b1, 16'h0002);
    chk("R9 D0 active after enable", dstate, 1);
    wr(1'b0, 16'hFFFF);
    rd(1'b0, rv); chk("R1 reserved bits zero", rv, 16'h0103);
    chk("R6 l1_req cleared by read", l1_req, 0);

    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 4; c++) begin
        for (int t = 0; t < 4; t++) begin
          bit d1, d2, keep, csup, tsup, legal, entry, srst;
          int ps_e, cmd_e, ds_e;
          d1 = s[0]; d2 = s[1]; keep = s[2];
          csup = !((c == 1 && !d1) || (c == 2 && !d2));
          if (!csup) continue;
          tsup = !((t == 1 && !d1) || (t == 2 && !d2));
          legal = tsup && (t == 0 || t >= c);
          entry = legal && t != 0 && t != c;
          srst  = legal && c == 3 && t == 0 && !keep;
          ps_e  = legal ? t : c;
          cmd_e = srst ? 0 : 7;
          ds_e  = (ps_e == 0) ? (cmd_e != 0 ? 1 : 0) : ps_e + 1;
          do_reset(d1, d2, keep);
          wr(1'b1, 16'h0007);
          if (c != 0) wr(1'b0, 16'h0100 | 16'(c));
          wr(1'b0, 16'h0100 | 16'(t));
          chk($sformatf("R5/R6 l1_req s=%0d %0d->%0d", s, c, t), l1_req, entry);
          chk($sformatf("R7/R8 soft_rst s=%0d %0d->%0d", s, c, t), soft_rst, srst);
          chk($sformatf("R9 dstate s=%0d %0d->%0d", s, c, t), dstate, ds_e);
          rd(1'b0, rv);
          chk($sformatf("R1 R2 R3 R4 pm word s=%0d %0d->%0d", s, c, t), rv,
              16'h0100 | (keep ? 16'h0004 : 16'h0000) | 16'(ps_e));
          chk($sformatf("R7 soft_rst single s=%0d %0d->%0d", s, c, t), soft_rst, 0);
          chk($sformatf("R6 l1 drop on read s=%0d %0d->%0d", s, c, t), l1_req, 0);
          rd(1'b1, rv);
          chk($sformatf("R7/R8 cmd word s=%0d %0d->%0d", s, c, t), rv, cmd_e);
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule